// File: doc/BRIEF.md
# 1-Wire Bus Master Core

This block is a byte-wide, register-mapped master for a single-wire open-drain bus. A host writes a command to run a bus reset with presence detection, or writes a data byte that the core shifts onto the line as eight timed slots. The byte sampled back from the line during those same slots can then be read from the data register. Completion events are latched as status flags. A single interrupt line, with selectable polarity, tells the host that an enabled event has occurred.

Every bus interval is counted in microsecond ticks taken from an external clock-enable pulse, so the core never counts raw clock cycles. A command bit selects a search-assist mode, and the core presents it on a port for a neighbouring accelerator to use. Register offsets can be spread across a wider address bus through an address-shift parameter.

Top module: `owm_core`

## Requirements
- R1: After reset, the command, status, enable and data registers all read 0, `dq_oe` is 0, `search_mode` is 0, and `irq` is 1 (no event is pending and the polarity bit is 0).
- R2: Writing 1 to command bit 0 while the core is idle drives `dq_oe` high for T_RST_LOW ticks and then releases the line. Command read bit 0 (busy) stays 1 until T_RST_LOW+T_RST_HIGH ticks have elapsed. At that point status bit 0 (reset done) is set.
- R3: `dq_in` is sampled T_PD_SAMPLE ticks after the line is released during a reset. The sample is placed in status bit 1, where 1 means no device answered.
- R4: Writing the data register (offset 1) while idle sends eight slots, least significant bit first. Each slot lasts T_SLOT ticks and begins with `dq_oe` high for T_W1_LOW ticks when the bit is 1, or T_W0_LOW ticks when the bit is 0.
- R5: In each slot, `dq_in` is sampled at tick T_SAMPLE. At the end of the byte the sampled bits (first slot in bit 0) can be read at offset 1, and status bit 2 (transmit empty) and status bit 3 (receive full) are both set.
- R6: A read of the status register (offset 2) clears status bits 0 and 2 and the pending interrupt. It leaves status bit 3 unchanged.
- R7: A read of the data register clears status bit 3.
- R8: An interrupt becomes pending when a reset ends with enable bit 0 set, or when a byte ends with enable bit 2 or bit 3 set. It stays pending until a status read. The enable register is offset 3. `irq` equals the pending state when enable bit 4 is 1, and its inverse when enable bit 4 is 0.
- R9: Command bit 1 is stored, driven on `search_mode` and read back at command bit 1. Writing it as 0 leaves the mode, and it starts no bus activity.
- R10: A data write or reset command issued while a reset or a byte is in progress is ignored. The transfer already running completes unchanged.
- R11: The register is selected by address bits [ADDR_SHIFT+2:ADDR_SHIFT]. The address bits below them are ignored.
- R12: Bus timing advances only on cycles where `tick_us` is 1, so every interval scales with the tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond from the prescaler |
| addr | input | ADDR_SHIFT+3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt line, polarity set by enable bit 4 |
| dq_oe | output | 1 | 1 pulls the bus line low |
| dq_in | input | 1 | Sensed level of the bus line |
| search_mode | output | 1 | Search-assist mode select for the accelerator |

## Verification
A responder model in the bench pulls the line low during the read portion of each slot when its own bit is 0. This makes the received byte the AND of the sent byte and the responder's byte. The vector table pairs sent and response patterns so that this AND can be told apart from either operand alone: all ones, all zeros, alternating bits and mixed nibbles. The low-pulse width is recorded for each slot. Those widths reveal bit order and slot shape, and with a slower tick they show that timing scales. Reset is run both with and without a device answering, and commands issued during a transfer check that the running byte finishes intact.

// File: rtl/owm_core.sv
module owm_core #(
  parameter int ADDR_SHIFT  = 0,
  parameter int T_RST_LOW   = 480,
  parameter int T_RST_HIGH  = 625,
  parameter int T_PD_SAMPLE = 70,
  parameter int T_SLOT      = 70,
  parameter int T_W1_LOW    = 6,
  parameter int T_W0_LOW    = 60,
  parameter int T_SAMPLE    = 15,
  localparam int AW = ADDR_SHIFT + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  output logic          dq_oe,
  input  logic          dq_in,
  output logic          search_mode
);
  localparam int RST_TOTAL = T_RST_LOW + T_RST_HIGH;
  localparam int CW = $clog2(RST_TOTAL + T_SLOT + 1);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_XFER} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [2:0]    bit_n;
  logic [7:0]    sh, rx_q;
  logic          rx_bit, pd_done, no_dev, tx_empty, rx_full, pend, srch;
  logic [4:0]    en_q;

  wire [2:0] sel    = addr[ADDR_SHIFT +: 3];
  wire       wr_cmd = wr_en && sel == 3'd0;
  wire       wr_dat = wr_en && sel == 3'd1;
  wire       wr_ien = wr_en && sel == 3'd3;
  wire       rd_st  = rd_en && sel == 3'd2;
  wire       rd_dat = rd_en && sel == 3'd1;
  wire       idle   = st == S_IDLE;

  wire rst_end  = st == S_RST  && tick_us && cnt == CW'(RST_TOTAL - 1);
  wire slot_end = st == S_XFER && tick_us && cnt == CW'(T_SLOT - 1);
  wire byte_end = slot_end && bit_n == 3'd7;
  wire [CW-1:0] low_len = sh[0] ? CW'(T_W1_LOW) : CW'(T_W0_LOW);
  wire event_hit = (rst_end && en_q[0]) || (byte_end && (en_q[2] || en_q[3]));

  assign dq_oe = (st == S_RST && cnt < CW'(T_RST_LOW)) || (st == S_XFER && cnt < low_len);
  assign irq = en_q[4] ? pend : ~pend;
  assign search_mode = srch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bit_n <= '0;
      sh <= '0;
      rx_q <= '0;
      rx_bit <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (wr_cmd && wdata[0]) st <= S_RST;
          else if (wr_dat) begin
            st <= S_XFER;
            sh <= wdata;
            bit_n <= '0;
          end
        end
        S_RST: if (tick_us) begin
          if (cnt == CW'(T_RST_LOW + T_PD_SAMPLE)) rx_bit <= dq_in;
          if (rst_end) begin
            st <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_XFER: if (tick_us) begin
          if (cnt == CW'(T_SAMPLE)) rx_bit <= dq_in;
          if (slot_end) begin
            cnt <= '0;
            sh <= {rx_bit, sh[7:1]};
            bit_n <= bit_n + 1'b1;
            if (bit_n == 3'd7) begin
              st <= S_IDLE;
              rx_q <= {rx_bit, sh[7:1]};
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_done <= 1'b0;
      no_dev <= 1'b0;
      tx_empty <= 1'b0;
      rx_full <= 1'b0;
      pend <= 1'b0;
      srch <= 1'b0;
      en_q <= '0;
      rdata <= '0;
    end else begin
      if (wr_cmd) srch <= wdata[1];
      if (wr_ien) en_q <= wdata[4:0];
      if (rst_end) no_dev <= rx_bit;
      if (rst_end) pd_done <= 1'b1;
      else if (rd_st) pd_done <= 1'b0;
      if (byte_end) tx_empty <= 1'b1;
      else if (rd_st) tx_empty <= 1'b0;
      if (byte_end) rx_full <= 1'b1;
      else if (rd_dat) rx_full <= 1'b0;
      if (event_hit) pend <= 1'b1;
      else if (rd_st) pend <= 1'b0;
      if (rd_en) begin
        case (sel)
          3'd0: rdata <= {6'b0, srch, !idle};
          3'd1: rdata <= rx_q;
          3'd2: rdata <= {4'b0, rx_full, tx_empty, no_dev, pd_done};
          3'd3: rdata <= {3'b0, en_q};
          default: rdata <= '0;
        endcase
      end
    end
  end

  assert_timer_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tick_us) |=> ($stable(cnt) && $stable(bit_n)));
  assert_done_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (rx_full && tx_empty && st == S_IDLE));
  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !rst_end && !byte_end) |=> (!pd_done && !tx_empty && !pend));
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rd_st) |=> pend);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && !slot_end && wr_en) |=> (st == S_XFER && $stable(bit_n)));
endmodule

// File: tb/owm_core_bench.sv
module owm_core_bench;
  localparam int SH = 1, RL = 20, RH = 30, PDS = 7, SL = 10, W1 = 1, W0 = 6, SMP = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, pres = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata, resp = 8'hFF;
  logic irq, dq_oe, search_mode, tick_us;
  int per = 1, tdiv = 0, tests = 0, fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= (tdiv >= per - 1) ? 0 : tdiv + 1;
  assign tick_us = (tdiv == 0);

  int hold = 0, slotk = -1, run = 0, lastw = 0;
  int widths [8];
  logic prev_oe = 0;
  wire dq_in = ~(dq_oe | (hold > 0) | pres);

  owm_core #(.ADDR_SHIFT(SH), .T_RST_LOW(RL), .T_RST_HIGH(RH), .T_PD_SAMPLE(PDS),
    .T_SLOT(SL), .T_W1_LOW(W1), .T_W0_LOW(W0), .T_SAMPLE(SMP)) u_owm_core (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq), .dq_oe(dq_oe),
    .dq_in(dq_in), .search_mode(search_mode));

  always @(posedge clk) begin
    prev_oe <= dq_oe;
    if (hold > 0) hold <= hold - 1;
    if (wr_en && addr[3:1] == 3'd1) slotk <= -1;
    else if (dq_oe && !prev_oe) begin
      slotk <= slotk + 1;
      if (slotk + 1 < 8 && !resp[slotk + 1]) hold <= 5 * per;
    end
    if (dq_oe && !prev_oe) run <= 1;
    else if (dq_oe) run <= run + 1;
    if (!dq_oe && prev_oe) begin
      lastw <= run;
      if (slotk >= 0 && slotk < 8) widths[slotk] <= run;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(r << SH); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int r, output logic [7:0] d);
    @(negedge clk);
    addr = 4'(r << SH); rd_en = 1;
    @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [23:0] VEC [6] = '{
    24'hFF_A5_A5, 24'h0F_FF_0F, 24'h3C_99_18,
    24'h00_FF_00, 24'hFF_FF_FF, 24'h81_7E_00};

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 cmd", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 enable", v, 0);
    rd(1, v); chk("R1 data", v, 0);
    chk("R1 irq", irq, 1); chk("R1 dq_oe", dq_oe, 0); chk("R1 search", search_mode, 0);

    wr(3, 8'h1D);
    rd(3, v); chk("R8 enable readback", v, 8'h1D);
    chk("R8 irq active-high idle", irq, 0);

    // R2/R3 reset with device present
    pres = 1;
    wr(0, 8'h01);
    rd(0, v); chk("R2 busy during reset", v, 1);
    waitc(RL + RH + 5);
    pres = 0;
    chk("R2 reset low width", lastw, RL);
    rd(0, v); chk("R2 busy cleared", v, 0);
    chk("R8 irq after reset", irq, 1);
    rd(2, v); chk("R3 present status", v, 8'h01);
    chk("R6 irq cleared by status read", irq, 0);
    rd(2, v); chk("R6 flags cleared", v, 0);

    // R3 no device
    wr(0, 8'h01);
    waitc(RL + RH + 5);
    rd(2, v); chk("R3 absent status", v, 8'h03);

    // R4/R5/R6/R7 vector walk
    for (int i = 0; i < 6; i++) begin
      resp = VEC[i][15:8];
      wr(1, VEC[i][23:16]);
      waitc(8 * SL + 6);
      for (int b = 0; b < 8; b++)
        chk("R4 slot low width", widths[b], VEC[i][16 + b] ? W1 : W0);
      chk("R8 irq byte", irq, 1);
      rd(2, v); chk("R5 status after byte", v, 8'h0E);
      rd(2, v); chk("R6 rx_full kept", v, 8'h0A);
      rd(1, v); chk("R5 received byte", v, VEC[i][7:0]);
      rd(2, v); chk("R7 rx_full cleared", v, 8'h02);
    end

    // R8 active-low polarity
    resp = 8'hFF;
    wr(3, 8'h0C);
    chk("R8 irq low-polarity idle", irq, 1);
    wr(1, 8'h55);
    waitc(8 * SL + 6);
    chk("R8 irq low-polarity pending", irq, 0);
    rd(2, v);
    chk("R8 irq low-polarity cleared", irq, 1);
    rd(1, v);

    // R10 ignored while busy
    wr(1, 8'h5A);
    waitc(20);
    wr(1, 8'h00);
    wr(0, 8'h01);
    waitc(8 * SL + 6);
    rd(1, v); chk("R10 byte unchanged", v, 8'h5A);
    chk("R10 no reset pulse", lastw, W0);
    rd(0, v); chk("R10 idle afterwards", v, 0);

    // R9 search mode
    wr(0, 8'h02);
    chk("R9 search on", search_mode, 1);
    rd(0, v); chk("R9 cmd readback", v, 8'h02);
    chk("R9 no bus activity", dq_oe, 0);
    wr(0, 8'h00);
    chk("R9 search off", search_mode, 0);

    // R11 low address bits ignored
    @(negedge clk);
    addr = 4'((3 << SH) | 1); rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk("R11 shifted address", rdata, 8'h0C);

    // R12 slower tick
    per = 3;
    wr(1, 8'h00);
    waitc(8 * SL * 3 + 10);
    chk("R12 scaled slot width", (widths[0] >= 16 && widths[0] <= 18) ? 1 : 0, 1);
    rd(1, v); chk("R12 byte at slow tick", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule